// File: doc/BRIEF.md
# Slot-Based Power Supply Sequencer

This block brings up to twelve supply rails up and down in a programmed order. Each rail enable output and each rail monitor flag is given a slot number. The block steps through the slots in ascending order and waits a coded delay in each one. By the end of a slot's delay, every monitored rail in that slot must report that it is above its undervoltage level. If a rail is late, or if a rail that was good later drops, the block shuts every rail off. It then latches a fault flag and records the lowest slot that holds a failing rail.

The slot named as the last one ends the power-up walk. A reset output is then held for a further fixed count of ticks, and after that the block is in its monitoring phase. When the enable pin or the software enable goes low, the rails are released in reverse slot order, starting from the highest slot reached. The release of each slot is separated by that slot's delay. All time is counted in ticks of a 25 µs timebase input, so a system can run a scaled timebase. A non-zero retry-mode field makes the block restart after a fault once a coded retry delay has passed. With a zero field the fault stays latched until the enables are removed.

Top module: `pwr_slot_seq`

## Requirements
- R1: After reset, and for as long as `enable_in` and `sw_enable` are not both 1, all `en_o` are 0, `reset_o` is 1, and no power-up starts. A power-up starts on the first clock where both are 1, and that start clears `fault_o` and sets `fail_slot_o` to 0.
- R2: A 4-bit delay code c gives a delay in ticks. The codes 0 to 15 give, in order: 1, 20, 40, 80, 120, 160, 240, 320, 400, 480, 1000, 4000, 8000, 16000, 32000 and 64000 ticks.
- R3: Power-up starts in slot 0, which drives no output and watches no rail. The walk leaves slot k after code(k) ticks, and each slot lasts exactly that many ticks. The outputs assigned to slot k rise together when slot k begins. The assignments are 4-bit fields, and field i, at bits [4i+3:4i] of `out_slot`, belongs to rail i.
- R4: A watched rail of slot k whose `uv_good` is still 0 when slot k's delay ends causes a fault. On that clock all `en_o` go to 0, `fault_o` goes to 1 and `reset_o` stays at 1.
- R5: Once a watched rail has shown `uv_good`=1 during power-up, reset hold or monitoring, a later 0 on that rail causes a fault on the next clock.
- R6: On a fault, `fail_slot_o` takes the lowest slot number among the rails that fail on that clock. Its value is never 0, and it stays unchanged for as long as `fault_o` is 1.
- R7: Only slots 1 to `final_slot` take part. An output or monitor assigned to slot 0, or to a slot above `final_slot`, is never driven and never causes a fault.
- R8: After the delay of the final slot ends, `reset_o` stays at 1 for RESET_TICKS more ticks and then falls, and monitoring begins.
- R9: When the enables drop while in monitoring, the outputs of `final_slot` fall on the next clock. The outputs of each lower slot s fall code(s+1) ticks after those of slot s+1.
- R10: When the enables drop during power-up, power-down starts from the slot in progress, whose outputs fall on the next clock. Slots that were not yet reached never turn on.
- R11: With `retry_mode`=0 a fault stays latched, with all outputs off, until the enables are removed. With a non-zero `retry_mode` the block restarts power-up from slot 0, which clears `fault_o`, code(`retry_code`) ticks after the fault, provided that both enables are 1.
- R12: Delays advance only on clocks where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock timebase pulse, one per 25 µs |
| enable_in | input | 1 | Enable pin |
| sw_enable | input | 1 | Software enable bit |
| uv_good | input | NUM_RAILS | Per-rail above-undervoltage flags |
| out_slot | input | NUM_RAILS*SLOT_W | Slot of each enable output |
| mon_slot | input | NUM_RAILS*SLOT_W | Slot of each monitored rail |
| slot_code | input | (NUM_RAILS+1)*4 | Delay code of each slot, slot 0 lowest |
| final_slot | input | SLOT_W | Last slot of the power-up walk |
| retry_mode | input | 2 | Zero latches faults; non-zero enables restart |
| retry_code | input | 4 | Delay code before a restart |
| en_o | output | NUM_RAILS | Rail enable outputs, active high |
| reset_o | output | 1 | System reset, active high |
| fault_o | output | 1 | Latched fault flag |
| fail_slot_o | output | 5 | Lowest slot of the failing rails |

## Verification
The assertions take for granted that the slot assignments, delay codes, final slot and retry settings stay fixed from the start of a power-up until the block is idle again. They also take for granted that `final_slot` does not exceed NUM_RAILS, and that `tick` is a single-clock pulse. The bench changes configuration only while reset is held. It derives each `uv_good` from the matching `en_o`, and a per-rail kill mask can force a rail low. The bench drives every input at the falling edge of the clock.

// File: rtl/pss_pkg.sv
package pss_pkg;

    localparam int CODE_W = 4;
    localparam int FAIL_W = 5;
    localparam int TICK_W = 20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UP,
        ST_HOLD,
        ST_RUN,
        ST_DOWN,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic drive;
        logic reached;
        logic current;
    } rail_dec_t;

    // Delay code to tick count (one tick = 25 us)
    function automatic logic [TICK_W-1:0] code_ticks(input logic [CODE_W-1:0] c);
        logic [TICK_W-1:0] t;
        case (c)
            4'd0:    t = TICK_W'(1);
            4'd1:    t = TICK_W'(20);
            4'd2:    t = TICK_W'(40);
            4'd3:    t = TICK_W'(80);
            4'd4:    t = TICK_W'(120);
            4'd5:    t = TICK_W'(160);
            4'd6:    t = TICK_W'(240);
            4'd7:    t = TICK_W'(320);
            4'd8:    t = TICK_W'(400);
            4'd9:    t = TICK_W'(480);
            4'd10:   t = TICK_W'(1000);
            4'd11:   t = TICK_W'(4000);
            4'd12:   t = TICK_W'(8000);
            4'd13:   t = TICK_W'(16000);
            4'd14:   t = TICK_W'(32000);
            default: t = TICK_W'(64000);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pss_timer.sv
module pss_timer
    import pss_pkg::*;
#(
    parameter int W = TICK_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);

    logic [W-1:0] cnt;

    // Fires on the tick that consumes the last remaining count
    assign expire = tick && (cnt == W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

endmodule

// File: rtl/pss_rail_dec.sv
module pss_rail_dec
    import pss_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic [SLOT_W-1:0] out_slot,
    input  logic [SLOT_W-1:0] mon_slot,
    input  logic [SLOT_W-1:0] cur_slot,
    input  logic [SLOT_W-1:0] last_slot,
    input  seq_state_e        state,
    output rail_dec_t         dec
);

    logic up_like;
    logic out_ok;
    logic watched;

    always_comb begin
        up_like = (state == ST_UP) || (state == ST_HOLD) || (state == ST_RUN);
        out_ok  = (out_slot != '0) && (out_slot <= last_slot);
        watched = (mon_slot != '0) && (mon_slot <= last_slot);

        dec.drive   = out_ok &&
                      ((up_like && (out_slot <= cur_slot)) ||
                       ((state == ST_DOWN) && (out_slot < cur_slot)));
        dec.reached = watched && (mon_slot <= cur_slot);
        dec.current = watched && (mon_slot == cur_slot);
    end

endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
    import pss_pkg::*;
#(
    parameter int NUM_RAILS   = 12,
    parameter int SLOT_W      = 4,
    parameter int RESET_TICKS = 200
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          run,
    input  logic [1:0]                    retry_mode,
    input  logic [CODE_W-1:0]             retry_code,
    input  logic [SLOT_W-1:0]             last_slot,
    input  logic [(NUM_RAILS+1)*CODE_W-1:0] slot_code,
    input  logic [NUM_RAILS*SLOT_W-1:0]   mon_slot,
    input  logic [NUM_RAILS-1:0]          uv_good,
    input  logic [NUM_RAILS-1:0]          reached,
    input  logic [NUM_RAILS-1:0]          current,
    input  logic                          expire,
    output seq_state_e                    state,
    output logic [SLOT_W-1:0]             cur_slot,
    output logic                          load,
    output logic [TICK_W-1:0]             load_val,
    output logic                          fault_o,
    output logic [FAIL_W-1:0]             fail_slot_o
);

    localparam int NUM_SLOTS = NUM_RAILS + 1;

    function automatic logic [CODE_W-1:0] code_at(input logic [SLOT_W-1:0] k,
                                                  input logic [NUM_SLOTS*CODE_W-1:0] codes);
        logic [CODE_W-1:0] r;
        r = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (SLOT_W'(s) == k) r = codes[s*CODE_W +: CODE_W];
        end
        return r;
    endfunction

    seq_state_e             state_n;
    logic [SLOT_W-1:0]      cur_n;
    logic [NUM_RAILS-1:0]   armed, armed_n;
    logic [NUM_RAILS-1:0]   fail_vec;
    logic                   fault_q, fault_n;
    logic [FAIL_W-1:0]      fail_q, fail_n;
    logic [FAIL_W-1:0]      lowest;
    logic                   live;

    assign fault_o     = fault_q;
    assign fail_slot_o = fail_q;
    assign live        = (state == ST_UP) || (state == ST_HOLD) || (state == ST_RUN);

    // Rails failing this clock: armed rails that dropped, late rails at slot end
    always_comb begin
        fail_vec = live ? (armed & ~uv_good) : '0;
        if (state == ST_UP && expire) begin
            fail_vec = fail_vec | (current & ~uv_good);
        end
    end

    always_comb begin
        lowest = '1;
        for (int i = 0; i < NUM_RAILS; i++) begin
            if (fail_vec[i] && (FAIL_W'(mon_slot[i*SLOT_W +: SLOT_W]) < lowest)) begin
                lowest = FAIL_W'(mon_slot[i*SLOT_W +: SLOT_W]);
            end
        end
    end

    always_comb begin
        state_n  = state;
        cur_n    = cur_slot;
        load     = 1'b0;
        load_val = '0;
        fault_n  = fault_q;
        fail_n   = fail_q;
        armed_n  = live ? (armed | (reached & uv_good)) : '0;

        case (state)
            ST_IDLE: begin
                if (run) begin
                    state_n  = ST_UP;
                    cur_n    = '0;
                    load     = 1'b1;
                    load_val = code_ticks(code_at('0, slot_code));
                    fault_n  = 1'b0;
                    fail_n   = '0;
                end
            end
            ST_UP, ST_HOLD, ST_RUN: begin
                if (fail_vec != '0) begin
                    state_n  = ST_FAULT;
                    load     = 1'b1;
                    load_val = code_ticks(retry_code);
                    fault_n  = 1'b1;
                    fail_n   = lowest;
                    armed_n  = '0;
                end else if (!run) begin
                    state_n  = ST_DOWN;
                    load     = 1'b1;
                    load_val = code_ticks(code_at(cur_slot, slot_code));
                    armed_n  = '0;
                end else if (expire) begin
                    if (state == ST_UP) begin
                        if (cur_slot == last_slot) begin
                            state_n  = ST_HOLD;
                            load     = 1'b1;
                            load_val = TICK_W'(RESET_TICKS);
                        end else begin
                            cur_n    = cur_slot + SLOT_W'(1);
                            load     = 1'b1;
                            load_val = code_ticks(code_at(cur_slot + SLOT_W'(1), slot_code));
                        end
                    end else if (state == ST_HOLD) begin
                        state_n = ST_RUN;
                    end
                end
            end
            ST_DOWN: begin
                if (expire) begin
                    if (cur_slot == '0) begin
                        state_n = ST_IDLE;
                    end else begin
                        cur_n    = cur_slot - SLOT_W'(1);
                        load     = 1'b1;
                        load_val = code_ticks(code_at(cur_slot - SLOT_W'(1), slot_code));
                    end
                end
            end
            ST_FAULT: begin
                if (retry_mode != 2'b00) begin
                    if (expire) begin
                        if (run) begin
                            state_n  = ST_UP;
                            cur_n    = '0;
                            load     = 1'b1;
                            load_val = code_ticks(code_at('0, slot_code));
                            fault_n  = 1'b0;
                            fail_n   = '0;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end else if (!run) begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_slot <= '0;
            armed    <= '0;
            fault_q  <= 1'b0;
            fail_q   <= '0;
        end else begin
            state    <= state_n;
            cur_slot <= cur_n;
            armed    <= armed_n;
            fault_q  <= fault_n;
            fail_q   <= fail_n;
        end
    end

endmodule

// File: rtl/pwr_slot_seq.sv
module pwr_slot_seq
    import pss_pkg::*;
#(
    parameter int NUM_RAILS   = 12,
    parameter int SLOT_W      = 4,
    parameter int RESET_TICKS = 200
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              tick,
    input  logic                              enable_in,
    input  logic                              sw_enable,
    input  logic [NUM_RAILS-1:0]              uv_good,
    input  logic [NUM_RAILS*SLOT_W-1:0]       out_slot,
    input  logic [NUM_RAILS*SLOT_W-1:0]       mon_slot,
    input  logic [(NUM_RAILS+1)*CODE_W-1:0]   slot_code,
    input  logic [SLOT_W-1:0]                 final_slot,
    input  logic [1:0]                        retry_mode,
    input  logic [CODE_W-1:0]                 retry_code,
    output logic [NUM_RAILS-1:0]              en_o,
    output logic                              reset_o,
    output logic                              fault_o,
    output logic [FAIL_W-1:0]                 fail_slot_o
);

    localparam int NUM_SLOTS = NUM_RAILS + 1;
    localparam logic [SLOT_W-1:0] TOP_SLOT = SLOT_W'(NUM_SLOTS - 1);

    seq_state_e          state;
    logic [SLOT_W-1:0]   cur_slot;
    logic [SLOT_W-1:0]   last_slot;
    logic                load;
    logic [TICK_W-1:0]   load_val;
    logic                expire;
    logic                run;
    logic [NUM_RAILS-1:0] reached_v;
    logic [NUM_RAILS-1:0] current_v;
    rail_dec_t           dec_w [NUM_RAILS];

    assign run       = enable_in && sw_enable;
    assign last_slot = (final_slot > TOP_SLOT) ? TOP_SLOT : final_slot;
    assign reset_o   = (state != ST_RUN);

    pss_timer #(.W(TICK_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (load),
        .load_val (load_val),
        .expire   (expire)
    );

    for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
        pss_rail_dec #(.SLOT_W(SLOT_W)) u_dec (
            .out_slot  (out_slot[g*SLOT_W +: SLOT_W]),
            .mon_slot  (mon_slot[g*SLOT_W +: SLOT_W]),
            .cur_slot  (cur_slot),
            .last_slot (last_slot),
            .state     (state),
            .dec       (dec_w[g])
        );
        assign en_o[g]      = dec_w[g].drive;
        assign reached_v[g] = dec_w[g].reached;
        assign current_v[g] = dec_w[g].current;
    end

    pss_ctrl #(
        .NUM_RAILS   (NUM_RAILS),
        .SLOT_W      (SLOT_W),
        .RESET_TICKS (RESET_TICKS)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .retry_mode  (retry_mode),
        .retry_code  (retry_code),
        .last_slot   (last_slot),
        .slot_code   (slot_code),
        .mon_slot    (mon_slot),
        .uv_good     (uv_good),
        .reached     (reached_v),
        .current     (current_v),
        .expire      (expire),
        .state       (state),
        .cur_slot    (cur_slot),
        .load        (load),
        .load_val    (load_val),
        .fault_o     (fault_o),
        .fail_slot_o (fail_slot_o)
    );

endmodule

// File: rtl/pwr_slot_seq_chk.sv
module pwr_slot_seq_chk #(
    parameter int NUM_RAILS = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 enable_in,
    input logic                 sw_enable,
    input logic [NUM_RAILS-1:0] en_o,
    input logic                 reset_o,
    input logic                 fault_o,
    input logic [4:0]           fail_slot_o
);

    // R1: an output may only turn on when both enables were present
    p_start_gate_r1: assert property (@(posedge clk) disable iff (rst)
        ((en_o & ~$past(en_o)) != '0) |-> $past(enable_in && sw_enable));

    // R4: a fault shuts every rail off and keeps reset asserted
    p_shutdown_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> (en_o == '0) && reset_o);

    // R6: a recorded failing slot is never slot 0
    p_fail_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fault_o) |-> (fail_slot_o != 5'd0));

    // R6: the failing slot holds while the fault stays latched
    p_fail_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (fault_o && $past(fault_o)) |-> $stable(fail_slot_o));

    // R8: reset is released only with enables present and no fault
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(reset_o) |-> ($past(enable_in && sw_enable) && !fault_o));

    // R10: with enables missing, no output turns on at the next clock
    p_no_rise_off_r10: assert property (@(posedge clk) disable iff (rst)
        !(enable_in && sw_enable) |=> ((en_o & ~$past(en_o)) == '0));

endmodule

bind pwr_slot_seq pwr_slot_seq_chk #(.NUM_RAILS(NUM_RAILS)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .enable_in   (enable_in),
    .sw_enable   (sw_enable),
    .en_o        (en_o),
    .reset_o     (reset_o),
    .fault_o     (fault_o),
    .fail_slot_o (fail_slot_o)
);

// File: tb/test_pwr_slot_seq.sv
module test_pwr_slot_seq;

    localparam int NR    = 12;
    localparam int SW    = 4;
    localparam int NS    = NR + 1;
    localparam int RST_T = 200;

    logic            clk = 1'b0;
    logic            rst;
    logic            tick;
    logic            enable_in;
    logic            sw_enable;
    logic [NR-1:0]   uv_good;
    logic [NR*SW-1:0] out_slot;
    logic [NR*SW-1:0] mon_slot;
    logic [NS*4-1:0] slot_code;
    logic [SW-1:0]   final_slot;
    logic [1:0]      retry_mode;
    logic [3:0]      retry_code;
    logic [NR-1:0]   en_o;
    logic            reset_o;
    logic            fault_o;
    logic [4:0]      fail_slot_o;

    logic [NR-1:0]   kill;
    int              tick_div;
    int              tick_cnt;
    int              n_chk;
    int              n_fail;

    int rail_slot [NR] = '{1, 1, 2, 3, 2, 4, 5, 3, 6, 0, 7, 9};
    int code_of   [NS] = '{1, 0, 2, 1, 4, 0, 0, 0, 0, 0, 0, 0, 0};

    always #2.5ns clk = ~clk;

    // Rail model: a rail is good while enabled, unless forced low
    assign uv_good = en_o & ~kill;

    always @(negedge clk) begin
        tick_cnt = tick_cnt + 1;
        tick     = ((tick_cnt % tick_div) == 0);
    end

    pwr_slot_seq #(.NUM_RAILS(NR), .SLOT_W(SW), .RESET_TICKS(RST_T)) i_pwr_slot_seq (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .enable_in   (enable_in),
        .sw_enable   (sw_enable),
        .uv_good     (uv_good),
        .out_slot    (out_slot),
        .mon_slot    (mon_slot),
        .slot_code   (slot_code),
        .final_slot  (final_slot),
        .retry_mode  (retry_mode),
        .retry_code  (retry_code),
        .en_o        (en_o),
        .reset_o     (reset_o),
        .fault_o     (fault_o),
        .fail_slot_o (fail_slot_o)
    );

    function automatic int ticks_of(input int c);
        int t [16] = '{1, 20, 40, 80, 120, 160, 240, 320, 400, 480,
                       1000, 4000, 8000, 16000, 32000, 64000};
        return t[c];
    endfunction

    function automatic int tsum(input int a, input int b);
        int s = 0;
        for (int k = a; k <= b; k++) s += ticks_of(code_of[k]);
        return s;
    endfunction

    function automatic logic [NR-1:0] slot_mask(input int s);
        logic [NR-1:0] m = '0;
        for (int i = 0; i < NR; i++) if (rail_slot[i] == s) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [NR-1:0] exp_on(input int cur);
        logic [NR-1:0] m = '0;
        for (int i = 0; i < NR; i++)
            if (rail_slot[i] >= 1 && rail_slot[i] <= cur) m[i] = 1'b1;
        return m;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // kind 0: mask all on, 1: mask all off, 2: reset low, 3: fault high, 4: fault low
    task automatic wait_for(input int kind, input logic [NR-1:0] mask, input string req,
                            output int n);
        bit hit = 0;
        n = 0;
        for (int k = 0; k < 20000 && !hit; k++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            case (kind)
                0: hit = ((en_o & mask) == mask);
                1: hit = ((en_o & mask) == '0);
                2: hit = !reset_o;
                3: hit = fault_o;
                default: hit = !fault_o;
            endcase
        end
        if (!hit) chk(1'b0, {req, " wait timeout"}, n, -1);
    endtask

    task automatic apply_reset(input int fin, input int rmode, input int rcode, input int div);
        @(negedge clk);
        rst        = 1'b1;
        enable_in  = 1'b1;
        sw_enable  = 1'b0;
        kill       = '0;
        tick_div   = div;
        final_slot = SW'(fin);
        retry_mode = 2'(rmode);
        retry_code = 4'(rcode);
        for (int i = 0; i < NR; i++) begin
            out_slot[i*SW +: SW] = SW'(rail_slot[i]);
            mon_slot[i*SW +: SW] = SW'(rail_slot[i]);
        end
        for (int s = 0; s < NS; s++) slot_code[s*4 +: 4] = 4'(code_of[s]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Start and follow the walk up to monitoring
    task automatic powerup_check(input int fin);
        int n, prev, base;
        prev = 0;
        base = 1;
        sw_enable = 1'b1;
        for (int s = 1; s <= fin; s++) begin
            if (slot_mask(s) != '0) begin
                wait_for(0, slot_mask(s), "R3", n);
                chk(n == base + tsum(prev, s - 1), "R3/R2 slot timing", n, base + tsum(prev, s - 1));
                chk(en_o == exp_on(s), "R3/R7 outputs at slot start", en_o, exp_on(s));
                base = 0;
                prev = s;
            end
        end
        wait_for(2, '0, "R8", n);
        chk(n == tsum(prev, fin) + RST_T, "R8 reset release", n, tsum(prev, fin) + RST_T);
        chk(en_o == exp_on(fin), "R7 outputs in monitoring", en_o, exp_on(fin));
        chk(!fault_o, "R7 no fault from unused rails", fault_o, 0);
    endtask

    task automatic test_reset_idle();
        apply_reset(7, 0, 0, 1);
        chk(en_o == '0 && reset_o && !fault_o && fail_slot_o == 0, "R1 reset state",
            {en_o, reset_o, fault_o}, 13'h1 << 1);
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk(en_o == '0 && reset_o, "R1 no start without sw_enable", en_o, 0);
        enable_in = 1'b0;
        sw_enable = 1'b1;
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk(en_o == '0 && reset_o, "R1 no start without enable_in", en_o, 0);
        chk(ticks_of(4) == 120, "R2 code 4 table value", ticks_of(4), 120);
    endtask

    task automatic test_up_down();
        int n, prev, base;
        apply_reset(7, 0, 0, 1);
        powerup_check(7);
        sw_enable = 1'b0;
        prev = 7;
        base = 1;
        for (int s = 7; s >= 1; s--) begin
            if (slot_mask(s) != '0) begin
                wait_for(1, slot_mask(s), "R9", n);
                chk(n == base + tsum(s + 1, prev), "R9 reverse timing", n, base + tsum(s + 1, prev));
                chk(en_o == exp_on(s - 1), "R9 remaining outputs", en_o, exp_on(s - 1));
                base = 0;
                prev = s;
            end
        end
        repeat (100) @(posedge clk);
        @(negedge clk);
        chk(reset_o && !fault_o, "R9 idle after power-down", reset_o, 1);
    endtask

    task automatic test_final9();
        apply_reset(9, 0, 0, 1);
        powerup_check(9);
        chk(en_o[11] == 1'b1 && en_o[9] == 1'b0, "R7 final slot 9", en_o, exp_on(9));
    endtask

    task automatic test_abort();
        int n;
        apply_reset(7, 0, 0, 1);
        sw_enable = 1'b1;
        wait_for(0, slot_mask(1), "R10", n);
        wait_for(0, slot_mask(2), "R10", n);
        enable_in = 1'b0;
        wait_for(1, slot_mask(2), "R10", n);
        chk(n == 1, "R10 current slot drops first", n, 1);
        chk(en_o == slot_mask(1), "R10 lower slot still on", en_o, slot_mask(1));
        wait_for(1, slot_mask(1), "R10", n);
        chk(n == ticks_of(code_of[2]), "R10 reverse delay", n, ticks_of(code_of[2]));
        repeat (200) @(posedge clk);
        @(negedge clk);
        chk(en_o == '0 && !fault_o, "R10 unreached slots never on", en_o, 0);
    endtask

    task automatic test_timeout_latched();
        int n;
        apply_reset(7, 0, 0, 1);
        kill[3] = 1'b1;
        sw_enable = 1'b1;
        wait_for(0, slot_mask(3), "R4", n);
        wait_for(3, '0, "R4", n);
        chk(n == ticks_of(code_of[3]), "R4 timeout at slot end", n, ticks_of(code_of[3]));
        chk(en_o == '0 && reset_o, "R4 shutdown", en_o, 0);
        chk(fail_slot_o == 3, "R6 failing slot", fail_slot_o, 3);
        repeat (300) @(posedge clk);
        @(negedge clk);
        chk(fault_o && en_o == '0 && fail_slot_o == 3, "R11 fault latched without retry",
            fault_o, 1);
        sw_enable = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        kill = '0;
        sw_enable = 1'b1;
        wait_for(4, '0, "R1", n);
        chk(n == 1 && fail_slot_o == 0, "R1 restart clears fault", n, 1);
    endtask

    task automatic test_loss_in_run();
        int n;
        apply_reset(7, 0, 0, 1);
        powerup_check(7);
        kill[10] = 1'b1;
        wait_for(3, '0, "R5", n);
        chk(n == 1, "R5 loss detected next clock", n, 1);
        chk(fail_slot_o == 7 && en_o == '0, "R5 failing slot 7", fail_slot_o, 7);
    endtask

    task automatic test_lowest();
        int n;
        apply_reset(7, 0, 0, 1);
        powerup_check(7);
        kill[8] = 1'b1;
        kill[2] = 1'b1;
        wait_for(3, '0, "R6", n);
        chk(fail_slot_o == 2, "R6 lowest failing slot", fail_slot_o, 2);
        repeat (20) @(posedge clk);
        @(negedge clk);
        chk(fail_slot_o == 2, "R6 failing slot held", fail_slot_o, 2);
    endtask

    task automatic test_retry();
        int n;
        apply_reset(7, 1, 2, 1);
        kill[3] = 1'b1;
        sw_enable = 1'b1;
        wait_for(3, '0, "R11", n);
        kill = '0;
        wait_for(4, '0, "R11", n);
        chk(n == ticks_of(2), "R11 retry delay", n, ticks_of(2));
        wait_for(2, '0, "R11", n);
        chk(!reset_o && !fault_o && en_o == exp_on(7), "R11 retry completes", en_o, exp_on(7));
    endtask

    task automatic test_tick_rate();
        int n;
        apply_reset(7, 0, 0, 4);
        sw_enable = 1'b1;
        wait_for(0, slot_mask(1), "R12", n);
        chk(n >= 1 + 4 * 19 + 1 && n <= 1 + 4 * 20, "R12 delay scales with tick", n, 1 + 4 * 20);
    endtask

    initial begin
        n_chk    = 0;
        n_fail   = 0;
        tick_cnt = 0;
        tick_div = 1;
        tick     = 1'b0;
        rst      = 1'b1;
        kill     = '0;
        test_reset_idle();
        test_up_down();
        test_final9();
        test_abort();
        test_timeout_latched();
        test_loss_in_run();
        test_lowest();
        test_retry();
        test_tick_rate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule